// File: doc/BRIEF.md
# Address Generation and Next-PC Unit

This block computes the addresses that a 16-bit, word-addressed processor core needs for every instruction: the effective address of loads, stores and address-load operations, and the value the program counter takes next. It holds the program counter in a register. All other arithmetic is combinational and works from the instruction word, the current PC, one base-register value, the three condition flags and a word that the caller has read from the trap vector table.

One adder serves all address forms. Its left operand is the incremented PC, the base register or zero. Its right operand is a sign-extended 6, 9 or 11-bit field, or a zero-extended 8-bit trap number. The caller reads the register file at `base_idx` and returns the value on `base_val`. On a trap, the caller reads memory at `ea` and returns that word on `vec_word`. When a subroutine call or trap is taken, the unit asks for the incremented PC to be written to R7. The unit steps only when `advance` is high. It has no streaming handshake, because every pin is a plain per-cycle control or data value.

Top module: `addr_nextpc_unit`

## Requirements
- R1: After reset the PC is RESET_PC (default 0x3000). On a clock edge with `advance` high the PC loads `next_pc`. With `advance` low the PC keeps its value.
- R2: For opcodes 0010, 0011, 1010, 1011 and 1110 (instr[15:12]), `ea` = PC+1 + sign-extended instr[8:0], and `next_pc` = PC+1.
- R3: For opcodes 0110 and 0111, `ea` = `base_val` + sign-extended instr[5:0]. For all opcodes, `base_idx` = instr[8:6].
- R4: Opcode 0000 is a conditional branch. Its mask bits are instr[11] for n, instr[10] for z and instr[9] for p, and they are compared with `nzp` = {n,z,p}. When any masked flag is set, `br_taken`=1 and `next_pc` = PC+1 + sign-extended instr[8:0]. Otherwise `next_pc` = PC+1.
- R5: A branch whose three mask bits are all 0 is never taken, whatever the flags.
- R6: Opcode 1100 (jump) and opcode 0100 with instr[11]=0 (register call) set `next_pc` = `ea` = `base_val`.
- R7: Opcode 0100 with instr[11]=1 sets `next_pc` = `ea` = PC+1 + sign-extended instr[10:0].
- R8: Opcode 1111 (trap) sets `ea` = zero-extended instr[7:0] and `next_pc` = `vec_word`.
- R9: `link_we` is 1 only for opcode 0100 and opcode 1111, and `link_data` then equals PC+1.
- R10: All other opcodes give `next_pc` = PC+1 and `ea` = PC+1, with `br_taken`=0 and `link_we`=0.
- R11: All address sums wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| advance | input | 1 | Load next_pc into the PC at this edge |
| instr | input | 16 | Current instruction word |
| base_val | input | 16 | Value of the register selected by base_idx |
| nzp | input | 3 | Condition flags {n,z,p} |
| vec_word | input | 16 | Word read from the trap table at ea |
| pc | output | 16 | Current program counter |
| base_idx | output | 3 | Base register index |
| ea | output | 16 | Adder result: effective or target address |
| next_pc | output | 16 | PC value for the next instruction |
| br_taken | output | 1 | Conditional branch taken |
| link_we | output | 1 | Write link_data into R7 |
| link_data | output | 16 | Return address |

## Verification
The hardest cases to reach are PC-relative sums that wrap past 0xFFFF or below 0x0000. These need particular starting PC values, and the PC can only be set through the unit's own behaviour. Before each vector, the bench therefore issues a register jump whose base value is the wanted start address and advances once. It then applies the instruction under test. This method reaches starting PCs such as 0xFFFF and 0x0050, and it allows extreme negative offsets in all three widths.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam logic [3:0] OP_BR   = 4'b0000;
  localparam logic [3:0] OP_LD   = 4'b0010;
  localparam logic [3:0] OP_ST   = 4'b0011;
  localparam logic [3:0] OP_CALL = 4'b0100;
  localparam logic [3:0] OP_LDR  = 4'b0110;
  localparam logic [3:0] OP_STR  = 4'b0111;
  localparam logic [3:0] OP_LDI  = 4'b1010;
  localparam logic [3:0] OP_STI  = 4'b1011;
  localparam logic [3:0] OP_JMP  = 4'b1100;
  localparam logic [3:0] OP_LEA  = 4'b1110;
  localparam logic [3:0] OP_TRAP = 4'b1111;

  typedef enum logic [1:0] {LHS_PCINC, LHS_BASE, LHS_ZERO} lhs_e;
  typedef enum logic [2:0] {OFS_NONE, OFS_S6, OFS_S9, OFS_S11, OFS_Z8} ofs_e;
  typedef enum logic [1:0] {NXT_SEQ, NXT_SUM, NXT_COND, NXT_VEC} nxt_e;

  typedef struct packed {
    lhs_e lhs;
    ofs_e ofs;
    nxt_e nxt;
    logic link;
  } ctrl_t;
endpackage

// File: rtl/agu_decode.sv
module agu_decode
  import agu_pkg::*;
(
  input  logic [3:0] opcode,
  input  logic       call_rel,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '{lhs: LHS_PCINC, ofs: OFS_NONE, nxt: NXT_SEQ, link: 1'b0};
    unique case (opcode)
      OP_LD, OP_ST, OP_LDI, OP_STI, OP_LEA: ctrl.ofs = OFS_S9;
      OP_BR: begin
        ctrl.ofs = OFS_S9;
        ctrl.nxt = NXT_COND;
      end
      OP_LDR, OP_STR: begin
        ctrl.lhs = LHS_BASE;
        ctrl.ofs = OFS_S6;
      end
      OP_JMP: begin
        ctrl.lhs = LHS_BASE;
        ctrl.nxt = NXT_SUM;
      end
      OP_CALL: begin
        ctrl.lhs  = call_rel ? LHS_PCINC : LHS_BASE;
        ctrl.ofs  = call_rel ? OFS_S11 : OFS_NONE;
        ctrl.nxt  = NXT_SUM;
        ctrl.link = 1'b1;
      end
      OP_TRAP: begin
        ctrl.lhs  = LHS_ZERO;
        ctrl.ofs  = OFS_Z8;
        ctrl.nxt  = NXT_VEC;
        ctrl.link = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/agu_offset.sv
module agu_offset
  import agu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] instr,
  input  ofs_e          sel,
  output logic [AW-1:0] offset
);
  localparam int NW = 4;
  localparam int WIDTHS [NW] = '{6, 9, 11, 8};

  logic [AW-1:0] ext [NW];

  for (genvar i = 0; i < NW; i++) begin : g_ext
    localparam int W = WIDTHS[i];
    if (i == NW - 1) begin : g_zero
      assign ext[i] = {{(AW-W){1'b0}}, instr[W-1:0]};
    end else begin : g_sign
      assign ext[i] = {{(AW-W){instr[W-1]}}, instr[W-1:0]};
    end
  end

  always_comb begin
    unique case (sel)
      OFS_S6:  offset = ext[0];
      OFS_S9:  offset = ext[1];
      OFS_S11: offset = ext[2];
      OFS_Z8:  offset = ext[3];
      default: offset = '0;
    endcase
  end
endmodule

// File: rtl/agu_pc_reg.sv
module agu_pc_reg #(
  parameter int            AW       = 16,
  parameter logic [AW-1:0] RESET_PC = 16'h3000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic [AW-1:0] pc_d,
  output logic [AW-1:0] pc_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       pc_q <= RESET_PC;
    else if (advance) pc_q <= pc_d;
  end

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(pc_q)); // R1
  AST_PC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> pc_q == $past(pc_d)); // R1
endmodule

// File: rtl/addr_nextpc_unit.sv
module addr_nextpc_unit
  import agu_pkg::*;
#(
  parameter int            AW       = 16,
  parameter logic [AW-1:0] RESET_PC = 16'h3000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic [15:0]   instr,
  input  logic [AW-1:0] base_val,
  input  logic [2:0]    nzp,
  input  logic [AW-1:0] vec_word,
  output logic [AW-1:0] pc,
  output logic [2:0]    base_idx,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] next_pc,
  output logic          br_taken,
  output logic          link_we,
  output logic [AW-1:0] link_data
);
  localparam logic [AW-1:0] ONE = AW'(1);

  ctrl_t         ctrl;
  logic [AW-1:0] pc_inc, lhs, offset, ext_instr;
  logic [3:0]    opcode;

  assign opcode    = instr[15:12];
  assign ext_instr = AW'(instr);
  assign base_idx  = instr[8:6];
  assign pc_inc    = pc + ONE;

  agu_decode u_dec (
    .opcode   (opcode),
    .call_rel (instr[11]),
    .ctrl     (ctrl)
  );

  agu_offset #(.AW(AW)) u_ofs (
    .instr  (ext_instr),
    .sel    (ctrl.ofs),
    .offset (offset)
  );

  always_comb begin
    unique case (ctrl.lhs)
      LHS_BASE: lhs = base_val;
      LHS_ZERO: lhs = '0;
      default:  lhs = pc_inc;
    endcase
  end

  assign ea = lhs + offset;

  assign br_taken = (ctrl.nxt == NXT_COND) && |(instr[11:9] & nzp);

  always_comb begin
    unique case (ctrl.nxt)
      NXT_SUM:  next_pc = ea;
      NXT_VEC:  next_pc = vec_word;
      NXT_COND: next_pc = br_taken ? ea : pc_inc;
      default:  next_pc = pc_inc;
    endcase
  end

  assign link_we   = ctrl.link;
  assign link_data = pc_inc;

  agu_pc_reg #(.AW(AW), .RESET_PC(RESET_PC)) u_pc (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (advance),
    .pc_d    (next_pc),
    .pc_q    (pc)
  );

  AST_ZERO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OP_BR && instr[11:9] == 3'b000) |-> next_pc == pc + ONE); // R5
  AST_TRAP_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    opcode == OP_TRAP |-> next_pc == vec_word); // R8
  AST_LINK_OPS: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (opcode == OP_CALL || opcode == OP_TRAP)); // R9
  AST_JMP_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    opcode == OP_JMP |-> next_pc == base_val); // R6
  AST_BR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> opcode == OP_BR); // R4
endmodule

// File: tb/addr_nextpc_unit_test.sv
module addr_nextpc_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;

  typedef struct packed {
    logic [15:0] start;
    logic [15:0] ins;
    logic [15:0] base;
    logic [2:0]  flags;
    logic [15:0] vec;
    logic [15:0] x_ea;
    logic [15:0] x_next;
    logic        x_lwe;
    logic [15:0] x_ldata;
  } vec_t;

  // R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 vectors
  localparam vec_t TBL [NV] = '{
    '{16'h3000, 16'h24FF, 16'h0000, 3'b000, 16'h0000, 16'h3100, 16'h3001, 1'b0, 16'h0000}, // R2 LD
    '{16'h3000, 16'hA7FF, 16'h0000, 3'b000, 16'h0000, 16'h3000, 16'h3001, 1'b0, 16'h0000}, // R2 LDI -1
    '{16'h2080, 16'h3001, 16'h0000, 3'b000, 16'h0000, 16'h2082, 16'h2081, 1'b0, 16'h0000}, // R2 ST
    '{16'h3000, 16'h638C, 16'h2035, 3'b000, 16'h0000, 16'h2041, 16'h3001, 1'b0, 16'h0000}, // R3 LDR
    '{16'h3000, 16'h7520, 16'h0010, 3'b000, 16'h0000, 16'hFFF0, 16'h3001, 1'b0, 16'h0000}, // R3 R11 STR wrap
    '{16'h0050, 16'hEB00, 16'h0000, 3'b000, 16'h0000, 16'hFF51, 16'h0051, 1'b0, 16'h0000}, // R2 R11 LEA
    '{16'h3000, 16'h0604, 16'h0000, 3'b010, 16'h0000, 16'h3005, 16'h3005, 1'b0, 16'h0000}, // R4 taken
    '{16'h3000, 16'h0804, 16'h0000, 3'b001, 16'h0000, 16'h3005, 16'h3001, 1'b0, 16'h0000}, // R4 not taken
    '{16'h3000, 16'h0004, 16'h0000, 3'b111, 16'h0000, 16'h3005, 16'h3001, 1'b0, 16'h0000}, // R5 zero mask
    '{16'h3010, 16'h0FFD, 16'h0000, 3'b100, 16'h0000, 16'h300E, 16'h300E, 1'b0, 16'h0000}, // R4 backward
    '{16'h3000, 16'hC140, 16'h3500, 3'b000, 16'h0000, 16'h3500, 16'h3500, 1'b0, 16'h0000}, // R6 JMP
    '{16'h3000, 16'h4BFF, 16'h0000, 3'b000, 16'h0000, 16'h3400, 16'h3400, 1'b1, 16'h3001}, // R7 R9 call
    '{16'h0100, 16'h4C00, 16'h0000, 3'b000, 16'h0000, 16'hFD01, 16'hFD01, 1'b1, 16'h0101}, // R7 R11 call
    '{16'h3000, 16'h4080, 16'h4000, 3'b000, 16'h0000, 16'h4000, 16'h4000, 1'b1, 16'h3001}, // R6 R9 reg call
    '{16'h3000, 16'hF025, 16'h0000, 3'b000, 16'h0520, 16'h0025, 16'h0520, 1'b1, 16'h3001}, // R8 R9 trap
    '{16'hFFFF, 16'h1244, 16'h0000, 3'b000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 16'h0000}, // R10 R11 ADD
    '{16'h1234, 16'h5000, 16'h7777, 3'b111, 16'hBEEF, 16'h1235, 16'h1235, 1'b0, 16'h0000}  // R10 AND
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        advance = 1'b0;
  logic [15:0] instr = 16'h0000;
  logic [15:0] base_val = 16'h0000;
  logic [2:0]  nzp = 3'b000;
  logic [15:0] vec_word = 16'h0000;
  logic [15:0] pc, ea, next_pc, link_data;
  logic [2:0]  base_idx;
  logic        br_taken, link_we;

  int tests = 0;
  int fails = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_nextpc_unit uut (
    .clk(clk), .rst_n(rst_n), .advance(advance), .instr(instr),
    .base_val(base_val), .nzp(nzp), .vec_word(vec_word), .pc(pc),
    .base_idx(base_idx), .ea(ea), .next_pc(next_pc), .br_taken(br_taken),
    .link_we(link_we), .link_data(link_data)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic goto_pc(input logic [15:0] a);
    instr = 16'hC140;
    base_val = a;
    advance = 1'b1;
    step();
    advance = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    step();
    step();
    rst_n = 1'b1;
    #1;
    check("R1 reset pc", pc, 16'h3000);

    for (int i = 0; i < NV; i++) begin
      goto_pc(TBL[i].start);
      check("R1 start pc", pc, TBL[i].start);
      instr = TBL[i].ins;
      base_val = TBL[i].base;
      nzp = TBL[i].flags;
      vec_word = TBL[i].vec;
      #1;
      check($sformatf("R2/R3/R7/R8 ea vec%0d", i), ea, TBL[i].x_ea);
      check($sformatf("R4/R6/R10 next vec%0d", i), next_pc, TBL[i].x_next);
      check($sformatf("R9 link_we vec%0d", i), 16'(link_we), 16'(TBL[i].x_lwe));
      if (TBL[i].x_lwe)
        check($sformatf("R9 link_data vec%0d", i), link_data, TBL[i].x_ldata);
      advance = 1'b1;
      step();
      advance = 1'b0;
      check($sformatf("R1 pc after advance vec%0d", i), pc, TBL[i].x_next);
    end

    // R3: base index field
    instr = 16'h638C;
    #1;
    check("R3 base_idx", 16'(base_idx), 16'h0006);

    // R4: br_taken flag, taken and not taken
    goto_pc(16'h3000);
    instr = 16'h0604; nzp = 3'b001;
    #1;
    check("R4 br_taken p", 16'(br_taken), 16'h0001);
    nzp = 3'b100;
    #1;
    check("R4 br_taken n miss", 16'(br_taken), 16'h0000);

    // R5: zero mask with every flag pattern
    for (int f = 0; f < 8; f++) begin
      nzp = 3'(f);
      instr = 16'h01FF;
      #1;
      check("R5 zero mask next", next_pc, 16'h3001);
    end

    // R1: hold with advance low across several edges
    instr = 16'hC140; base_val = 16'h9999;
    step(); step();
    check("R1 hold", pc, 16'h3000);

    // R1: reset returns pc to reset value
    goto_pc(16'h4444);
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    check("R1 reset again", pc, 16'h3000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule